// File: doc/BRIEF.md
# Stereo Disparity Fusion and Grey Scaler

This block sits at the back end of a stereo depth pipeline. It receives two disparity streams in raster order. One was found with the left image as reference and the other with the right image as reference. It merges them into one final disparity per pixel. The right-referenced result for a scene point sits a fixed number of columns (`SHIFT`) further along the line than the left-referenced one. The block therefore holds each left disparity in a short delay line until its right partner arrives. It then keeps the smaller of the two values.

Near the end of a line, a left pixel's partner column would fall past the last pixel. The last `SHIFT` left pixels of each line therefore have no partner. They are emitted unchanged, and they leave the delay line while the first `SHIFT` pixels of the following line are accepted.

Each final disparity goes to a constant lookup table that maps it onto an 8-bit grey level for display. The table needs no multiplier or divider. Both the fused disparity and its grey level are presented together with a single valid flag.

Top module: `disp_fuse_grey`

## Requirements
- R1: After reset, `out_valid`, `out_disp` and `out_grey` are 0. The first `SHIFT` accepted beats after reset produce no output.
- R2: Within a line, left pixel x is paired with right pixel x+`SHIFT`. The fused result is emitted for the beat that carries right pixel x+`SHIFT`, and `out_disp` equals the minimum of the two disparities.
- R3: A paired result never exceeds either of its two operands.
- R4: The last `SHIFT` left pixels of a line are emitted unchanged, in column order, on the first `SHIFT` beats of the next line. The right disparities on those beats have no effect on them.
- R5: A beat is a cycle with `l_valid` high. Each output appears exactly two clock cycles after the beat that releases it, and `out_valid` is high in no other cycle. Cycles without a beat neither shift the delay line nor change the pairing.
- R6: `out_grey` equals floor(`out_disp` × 256 / `DMAX`) whenever that value is below 256.
- R7: When `out_disp` × 256 / `DMAX` is 256 or more, which includes any disparity at or above `DMAX`, `out_grey` is 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_valid | input | 1 | Beat qualifier for the left-referenced stream |
| l_eol | input | 1 | High on the beat that carries the last pixel of a line |
| l_disp | input | 8 | Left-referenced disparity |
| r_valid | input | 1 | Beat qualifier for the right-referenced stream; must equal `l_valid` |
| r_disp | input | 8 | Right-referenced disparity for the same column as `l_disp` |
| out_valid | output | 1 | Fused result valid |
| out_disp | output | 8 | Final fused disparity |
| out_grey | output | 8 | Grey level derived from `out_disp` |

## Verification
The checker relies on three conditions at the inputs. The two streams advance in lockstep, so `r_valid` always equals `l_valid`. Every line is at least `SHIFT` beats long, which keeps the single line-parity tag sufficient to tell the current line from the previous one. `l_eol` marks exactly the last beat of each line. The bench meets all three by driving both valid inputs from one variable, using 16-pixel lines against a shift of 4, and raising the end-of-line flag only on column 15. It also inserts idle cycles between beats on some lines, which leaves these conditions intact.

// File: rtl/dfuse_pkg.sv
package dfuse_pkg;

    localparam int unsigned DISP_W   = 8;
    localparam int unsigned GREY_W   = 8;
    localparam int unsigned LEVELS   = 2 ** DISP_W;
    localparam int unsigned GREY_MAX = (2 ** GREY_W) - 1;

    // One slot of the left-stream delay line
    typedef struct packed {
        logic              vld;
        logic              tag;   // line parity at the time of capture
        logic [DISP_W-1:0] d;
    } slot_t;

    // Constant grey level for one disparity code, saturating at full scale
    function automatic logic [GREY_W-1:0] grey_level(input int unsigned d,
                                                     input int unsigned dmax);
        int unsigned q;
        q = (d << GREY_W) / dmax;
        if (q > GREY_MAX) return GREY_W'(GREY_MAX);
        return GREY_W'(q);
    endfunction

endpackage

// File: rtl/dfuse_align.sv
module dfuse_align
    import dfuse_pkg::*;
#(
    parameter int unsigned SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic              eol,
    input  logic [DISP_W-1:0] l_disp,
    output slot_t             pop,
    output logic              cur_tag
);

    slot_t line_q [SHIFT];
    logic  tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SHIFT; k++) line_q[k] <= '0;
            tag_q <= 1'b0;
        end else if (beat) begin
            line_q[0] <= '{vld: 1'b1, tag: tag_q, d: l_disp};
            for (int k = 1; k < SHIFT; k++) line_q[k] <= line_q[k-1];
            if (eol) tag_q <= ~tag_q;
        end
    end

    assign pop     = line_q[SHIFT-1];
    assign cur_tag = tag_q;

endmodule

// File: rtl/dfuse_select.sv
module dfuse_select
    import dfuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic              r_valid,
    input  logic [DISP_W-1:0] r_disp,
    input  slot_t             pop,
    input  logic              cur_tag,
    output logic              sel_v,
    output logic [DISP_W-1:0] sel_d
);

    logic              partnered;
    logic [DISP_W-1:0] fused;

    always_comb begin
        partnered = r_valid && (pop.tag == cur_tag);
        fused     = pop.d;
        if (partnered && (r_disp < pop.d)) fused = r_disp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_v <= 1'b0;
            sel_d <= '0;
        end else begin
            sel_v <= beat && pop.vld;
            if (beat && pop.vld) sel_d <= fused;
        end
    end

endmodule

// File: rtl/dfuse_scale.sv
module dfuse_scale
    import dfuse_pkg::*;
#(
    parameter int unsigned DMAX = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_v,
    input  logic [DISP_W-1:0] in_d,
    output logic              out_v,
    output logic [DISP_W-1:0] out_d,
    output logic [GREY_W-1:0] out_g
);

    logic [GREY_W-1:0] lut [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_entry
        assign lut[g] = grey_level(g, DMAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_d <= '0;
            out_g <= '0;
        end else begin
            out_v <= in_v;
            if (in_v) begin
                out_d <= in_d;
                out_g <= lut[in_d];
            end
        end
    end

endmodule

// File: rtl/disp_fuse_grey.sv
module disp_fuse_grey
    import dfuse_pkg::*;
#(
    parameter int unsigned SHIFT = 4,
    parameter int unsigned DMAX  = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       l_valid,
    input  logic       l_eol,
    input  logic [7:0] l_disp,
    input  logic       r_valid,
    input  logic [7:0] r_disp,
    output logic       out_valid,
    output logic [7:0] out_disp,
    output logic [7:0] out_grey
);

    slot_t             pop;
    logic              cur_tag;
    logic              sel_v;
    logic [DISP_W-1:0] sel_d;

    dfuse_align #(.SHIFT(SHIFT)) u_align (
        .clk     (clk),
        .rst     (rst),
        .beat    (l_valid),
        .eol     (l_eol),
        .l_disp  (l_disp),
        .pop     (pop),
        .cur_tag (cur_tag)
    );

    dfuse_select u_select (
        .clk     (clk),
        .rst     (rst),
        .beat    (l_valid),
        .r_valid (r_valid),
        .r_disp  (r_disp),
        .pop     (pop),
        .cur_tag (cur_tag),
        .sel_v   (sel_v),
        .sel_d   (sel_d)
    );

    dfuse_scale #(.DMAX(DMAX)) u_scale (
        .clk   (clk),
        .rst   (rst),
        .in_v  (sel_v),
        .in_d  (sel_d),
        .out_v (out_valid),
        .out_d (out_disp),
        .out_g (out_grey)
    );

endmodule

// File: rtl/dfuse_checker.sv
module dfuse_checker
    import dfuse_pkg::*;
#(
    parameter int unsigned DMAX = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              l_valid,
    input logic              r_valid,
    input logic [7:0]        r_disp,
    input slot_t             pop,
    input logic              cur_tag,
    input logic              sel_v,
    input logic [DISP_W-1:0] sel_d,
    input logic              out_valid,
    input logic [7:0]        out_disp,
    input logic [7:0]        out_grey
);

    // input contract behind R2: both streams advance together
    p_stream_lockstep_r2: assert property (@(posedge clk) disable iff (rst)
        l_valid == r_valid);

    p_out_from_beat_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(l_valid, 2));

    p_fuse_le_left_r3: assert property (@(posedge clk) disable iff (rst)
        sel_v |-> sel_d <= $past(pop.d));

    p_fuse_le_right_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_v && $past(r_valid && (pop.tag == cur_tag))) |-> sel_d <= $past(r_disp));

    p_grey_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_disp == 8'd0) |-> out_grey == 8'd0);

    p_grey_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && 32'(out_disp) >= DMAX) |-> out_grey == 8'hFF);

endmodule

bind disp_fuse_grey dfuse_checker #(.DMAX(DMAX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .l_valid   (l_valid),
    .r_valid   (r_valid),
    .r_disp    (r_disp),
    .pop       (pop),
    .cur_tag   (cur_tag),
    .sel_v     (sel_v),
    .sel_d     (sel_d),
    .out_valid (out_valid),
    .out_disp  (out_disp),
    .out_grey  (out_grey)
);

// File: tb/disp_fuse_grey_bench.sv
module disp_fuse_grey_bench;

    localparam int SHIFT = 4;
    localparam int DMAX  = 15;
    localparam int W     = 16;
    localparam int QN    = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       l_valid = 1'b0;
    logic       l_eol = 1'b0;
    logic [7:0] l_disp = '0;
    logic       r_valid = 1'b0;
    logic [7:0] r_disp = '0;
    logic       out_valid;
    logic [7:0] out_disp;
    logic [7:0] out_grey;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int cur_l [W];
    int cur_r [W];
    int prev_l [W];
    bit have_prev = 1'b0;

    int exp_d   [QN];
    int exp_c   [QN];
    bit exp_tl  [QN];
    int wr = 0;
    int rd = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    disp_fuse_grey #(.SHIFT(SHIFT), .DMAX(DMAX)) u_disp_fuse_grey (
        .clk(clk), .rst(rst), .l_valid(l_valid), .l_eol(l_eol), .l_disp(l_disp),
        .r_valid(r_valid), .r_disp(r_disp),
        .out_valid(out_valid), .out_disp(out_disp), .out_grey(out_grey)
    );

    function automatic int grey_of(int d);
        int q;
        q = (d * 256) / DMAX;
        return (q > 255) ? 255 : q;
    endfunction

    task automatic push(int d, bit tail);
        exp_d[wr % QN]  = d;
        exp_c[wr % QN]  = cyc + 2;
        exp_tl[wr % QN] = tail;
        wr++;
    endtask

    task automatic drive_line(bit bubbles);
        for (int x = 0; x < W; x++) begin
            if (bubbles && (x % 3 == 1)) begin
                @(negedge clk);
                l_valid = 1'b0; r_valid = 1'b0; l_eol = 1'b0;
            end
            @(negedge clk);
            l_valid = 1'b1; r_valid = 1'b1;
            l_disp = 8'(cur_l[x]); r_disp = 8'(cur_r[x]);
            l_eol = (x == W - 1);
            if (x >= SHIFT)
                push((cur_l[x-SHIFT] < cur_r[x]) ? cur_l[x-SHIFT] : cur_r[x], 1'b0);
            else if (have_prev)
                push(prev_l[W-SHIFT+x], 1'b1);
        end
        for (int x = 0; x < W; x++) prev_l[x] = cur_l[x];
        have_prev = 1'b1;
    endtask

    // output monitor: order, value, grey level and timing
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (rd == wr) begin
                    checks++; fails++;
                    $display("FAIL R1 R5 unexpected output at cycle %0d: actual disp %0d, expected none", cyc, out_disp);
                end else begin
                    int ed;
                    int eg;
                    ed = exp_d[rd % QN];
                    eg = grey_of(ed);
                    checks++;
                    if (exp_c[rd % QN] != cyc) begin
                        fails++;
                        $display("FAIL R5 output cycle: actual %0d expected %0d", cyc, exp_c[rd % QN]);
                    end
                    checks++;
                    if (int'(out_disp) != ed) begin
                        fails++;
                        if (exp_tl[rd % QN])
                            $display("FAIL R4 tail disparity: actual %0d expected %0d", out_disp, ed);
                        else
                            $display("FAIL R2 R3 fused disparity: actual %0d expected %0d", out_disp, ed);
                    end
                    checks++;
                    if (int'(out_grey) != eg) begin
                        fails++;
                        if ((ed * 256) / DMAX > 255)
                            $display("FAIL R7 saturated grey for %0d: actual %0d expected %0d", ed, out_grey, eg);
                        else
                            $display("FAIL R6 grey for %0d: actual %0d expected %0d", ed, out_grey, eg);
                    end
                    rd++;
                end
            end else if (rd != wr && exp_c[rd % QN] <= cyc) begin
                checks++; fails++;
                $display("FAIL R5 missing output at cycle %0d: actual none expected disp %0d", cyc, exp_d[rd % QN]);
                rd++;
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_up();
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_disp !== 8'd0 || out_grey !== 8'd0) begin
            fails++;
            $display("FAIL R1 reset state: actual v%0b d%0d g%0d expected v0 d0 g0", out_valid, out_disp, out_grey);
        end
        rst = 1'b0;

        // Full sweep of all disparity codes through the grey table (R6 R7)
        for (int y = 0; y < 16; y++) begin
            for (int x = 0; x < W; x++) begin
                cur_l[x] = y * 16 + x;
                cur_r[x] = 255;
            end
            drive_line(1'b0);
        end

        // Mixed patterns, idle cycles on odd lines (R2 R3 R5)
        for (int y = 0; y < 6; y++) begin
            for (int x = 0; x < W; x++) begin
                cur_l[x] = (x * 7 + y * 3) % 20;
                cur_r[x] = (x * 5 + y * 11) % 20;
            end
            drive_line(y % 2 == 1);
        end

        // Tails must ignore small right values (R4)
        for (int y = 0; y < 2; y++) begin
            for (int x = 0; x < W; x++) begin
                cur_l[x] = 10 + x;
                cur_r[x] = 0;
            end
            drive_line(1'b0);
        end

        // Closing line releases the previous tail
        for (int x = 0; x < W; x++) begin
            cur_l[x] = 1;
            cur_r[x] = 2;
        end
        drive_line(1'b1);

        @(negedge clk);
        l_valid = 1'b0; r_valid = 1'b0; l_eol = 1'b0;
        repeat (6) @(negedge clk);

        checks++;
        if (rd != wr) begin
            fails++;
            $display("FAIL R5 outputs received: actual %0d expected %0d", rd, wr);
        end
        finish_up();
    end

endmodule